// File: doc/BRIEF.md
# Framed Stepper Pulse-Train Generator

This block drives the step, direction and drive-enable signals of one stepper motor channel. Software writes four byte-wide settings registers through a simple write port. These registers hold a control byte, a two-byte step interval and a byte that stores two 4-bit current-reference codes. The settings are only shadow copies. They have no effect until a frame-start strobe arrives.

On each frame strobe the block copies the shadow settings into its working state and starts a new burst. It then emits one-cycle step pulses, one at the end of each programmed interval, until it has produced four times the programmed count. After that it stays quiet until the next strobe. The direction, drive-enable and current-reference outputs also change only at a frame strobe. A strobe that arrives during a burst abandons that burst and starts a new one.

Top module: `step_burst_gen`

## Requirements
- R1: `dir_o` takes bit 7 of the control byte at each frame strobe, where 0 means forward and 1 means reverse.
- R2: `drive_en_o` takes bit 6 of the control byte at each frame strobe, where 0 requests high impedance and 1 requests conduction.
- R3: Each frame produces exactly count×4 step pulses, where count is bits 5..0 of the control byte. A count of 0 produces no pulses.
- R4: The step interval P is {period-high bits 6..0, period-low bits 7..0} in clock cycles, and a value of 0 acts as 1. The k-th pulse is high in the cycle that follows the clock edge P×k cycles after the edge that sampled the frame strobe.
- R5: When P is at least 2, every step pulse is high for exactly one clock cycle.
- R6: When the enable bit is 0, no step pulse occurs in that frame, whatever the count.
- R7: `iref_o` takes bits 3..0 of the reference byte when bit 7 of the period-high byte is 0, and bits 7..4 when that bit is 1. The code is sampled at the frame strobe.
- R8: A register write has no effect on any output until the next frame strobe. A strobe that arrives during a burst restarts the burst with the current settings.
- R9: After the last pulse of a burst, `step_o` stays low until the next frame strobe.
- R10: After reset all outputs are 0 and no pulse occurs before the first frame strobe.
- R11: The write addresses are 0 for the control byte, 1 for period-low, 2 for period-high and 3 for the reference byte. A write takes effect on the clock edge at which `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| frame_start | input | 1 | Frame strobe that loads the settings and starts a burst |
| step_o | output | 1 | Step pulse |
| dir_o | output | 1 | Direction (1 = reverse) |
| drive_en_o | output | 1 | Drive enable (0 = high impedance) |
| iref_o | output | 4 | Selected current-reference code |

## Verification
The assertions assume that `frame_start` is a single-cycle strobe and that `rst_n` stays low for at least one clock edge before the block is used. They place no limit on how often strobes may come. The stimulus raises the strobe for exactly one cycle and issues each write on its own cycle, apart from any strobe. This keeps the shadow-to-working copy unambiguous. Intervals are kept short so that bursts finish quickly, except in one case with a nine-bit interval, which exercises the upper period byte.

// File: rtl/sbg_pkg.sv
// Package for the step burst generator: register addresses, field widths and
// the shadow register bank type. Assumes the byte layout stays fixed.
package sbg_pkg;

    localparam int BYTE_W      = 8;
    localparam int NUM_REGS    = 4;
    localparam int ADDR_W      = $clog2(NUM_REGS);
    localparam int CNT_W       = 6;
    localparam int SCALE_SHIFT = 2;
    localparam int BURST_W     = CNT_W + SCALE_SHIFT;
    localparam int PERIOD_W    = 15;
    localparam int REF_W       = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_PER_LO = 2'd1;
    localparam logic [ADDR_W-1:0] A_PER_HI = 2'd2;
    localparam logic [ADDR_W-1:0] A_REFS   = 2'd3;

    // Bit positions inside the control and period-high bytes.
    localparam int DIR_BIT = 7;
    localparam int EN_BIT  = 6;
    localparam int SEL_BIT = 7;

    typedef logic [NUM_REGS-1:0][BYTE_W-1:0] sbg_bank_t;

endpackage

// File: rtl/sbg_regfile.sv
// Shadow register bank. Holds the bytes written through the write port.
// Assumes that at most one write arrives per cycle. Its contents reach the
// outputs only through the frame latch.
module sbg_regfile
    import sbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output sbg_bank_t         bank
);

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        logic hit;
        assign hit = wr_en && (wr_addr == ADDR_W'(gi));

        // Capture the write data when this byte is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank[gi] <= '0;
            end else if (hit) begin
                bank[gi] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/sbg_frame_latch.sv
// Working copy of the per-frame static outputs: direction, drive enable and
// the selected current-reference nibble. These load only on a frame strobe.
module sbg_frame_latch
    import sbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  sbg_bank_t        bank,
    output logic             dir_q,
    output logic             en_q,
    output logic [REF_W-1:0] iref_q
);

    logic [REF_W-1:0] iref_pick;

    // Pick the reference nibble named by the select bit.
    always_comb begin
        if (bank[A_PER_HI][SEL_BIT]) begin
            iref_pick = bank[A_REFS][2*REF_W-1:REF_W];
        end else begin
            iref_pick = bank[A_REFS][REF_W-1:0];
        end
    end

    // Copy the shadow settings into the working state on each frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            en_q   <= 1'b0;
            iref_q <= '0;
        end else if (load) begin
            dir_q  <= bank[A_CTRL][DIR_BIT];
            en_q   <= bank[A_CTRL][EN_BIT];
            iref_q <= iref_pick;
        end
    end

endmodule

// File: rtl/sbg_pulse_engine.sv
// Burst engine. On a start strobe it loads a pulse budget and an interval.
// It then raises a one-cycle step at the end of each interval until the
// budget runs out. Assumes start is a single-cycle strobe. An interval of 0
// is treated as 1.
module sbg_pulse_engine
    import sbg_pkg::*;
#(
    parameter int P_W = PERIOD_W,
    parameter int B_W = BURST_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [B_W-1:0] burst_len,
    input  logic [P_W-1:0] period,
    output logic           step
);

    logic [P_W-1:0] tick_q;
    logic [P_W-1:0] tick_nxt;
    logic [P_W-1:0] period_q;
    logic [P_W-1:0] period_eff;
    logic [B_W-1:0] left_q;
    logic           active_q;
    logic           step_q;
    logic           tick_end;

    // Map a zero interval onto the shortest legal one.
    always_comb begin
        period_eff = (period == '0) ? P_W'(1) : period;
        tick_nxt   = tick_q + 1'b1;
        tick_end   = (tick_nxt == period_q);
    end

    // Interval counter, pulse budget and step register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q   <= '0;
            period_q <= P_W'(1);
            left_q   <= '0;
            active_q <= 1'b0;
            step_q   <= 1'b0;
        end else if (start) begin
            tick_q   <= '0;
            period_q <= period_eff;
            left_q   <= burst_len;
            active_q <= (burst_len != '0);
            step_q   <= 1'b0;
        end else if (active_q) begin
            if (tick_end) begin
                tick_q   <= '0;
                step_q   <= 1'b1;
                left_q   <= left_q - 1'b1;
                active_q <= (left_q != B_W'(1));
            end else begin
                tick_q   <= tick_nxt;
                step_q   <= 1'b0;
            end
        end else begin
            step_q <= 1'b0;
        end
    end

    assign step = step_q;

    // R5: a pulse lasts one cycle when the interval is longer than one cycle.
    a_r5_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q && period_q > P_W'(1)) |=> !step_q);

    // R9: once the burst is over, the step output stays low.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !start) |=> !step_q);

    // R3: every emitted pulse uses up exactly one unit of the budget.
    a_r3_budget_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !start && tick_end) |=> (step_q && left_q == $past(left_q) - 1'b1));

    // R4: the interval counter never reaches the latched interval.
    a_r4_tick_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (tick_q < period_q));

endmodule

// File: rtl/step_burst_gen.sv
// Top of the framed step pulse generator. Connects the shadow registers, the
// frame latch for the static outputs and the burst engine. The pulse budget
// is the stored count scaled by four, and it is zero when the enable bit is
// clear. Assumes frame_start is a single-cycle strobe.
module step_burst_gen
    import sbg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        frame_start,
    output logic        step_o,
    output logic        dir_o,
    output logic        drive_en_o,
    output logic [3:0]  iref_o
);

    sbg_bank_t             bank;
    logic [BURST_W-1:0]    burst_len;
    logic [PERIOD_W-1:0]   period_raw;

    sbg_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bank    (bank)
    );

    sbg_frame_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (frame_start),
        .bank   (bank),
        .dir_q  (dir_o),
        .en_q   (drive_en_o),
        .iref_q (iref_o)
    );

    // Scale the stored count and assemble the interval from its two bytes.
    always_comb begin
        if (bank[A_CTRL][EN_BIT]) begin
            burst_len = {bank[A_CTRL][CNT_W-1:0], {SCALE_SHIFT{1'b0}}};
        end else begin
            burst_len = '0;
        end
        period_raw = {bank[A_PER_HI][PERIOD_W-BYTE_W-1:0], bank[A_PER_LO]};
    end

    sbg_pulse_engine #(
        .P_W (PERIOD_W),
        .B_W (BURST_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (frame_start),
        .burst_len (burst_len),
        .period    (period_raw),
        .step      (step_o)
    );

    // R8: static outputs change only at a frame strobe.
    a_r8_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(dir_o) && $stable(drive_en_o) && $stable(iref_o)));

    // R6: a step pulse only occurs in a frame with the drive enabled.
    a_r6_step_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> drive_en_o);

endmodule

// File: tb/step_burst_gen_test.sv
module step_burst_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       frame_start = 1'b0;
    logic       step_o, dir_o, drive_en_o;
    logic [3:0] iref_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    int   cyc = 0;
    int   nxt = 0;
    int   left = 0;
    int   per = 1;
    logic [7:0] m_ctl = 0, m_lo = 0, m_hi = 0, m_ref = 0;
    logic e_step = 0, e_dir = 0, e_en = 0;
    logic [3:0] e_iref = 0;

    int  pulses = 0;
    int  consec = 0;
    logic prev_step = 1'b0;

    step_burst_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_start(frame_start), .step_o(step_o),
        .dir_o(dir_o), .drive_en_o(drive_en_o), .iref_o(iref_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: pulse k is due P*k cycles after the strobe cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; left = 0; nxt = 0; per = 1;
            m_ctl = 0; m_lo = 0; m_hi = 0; m_ref = 0;
            e_step = 0; e_dir = 0; e_en = 0; e_iref = 0;
        end else begin
            cyc = cyc + 1;
            if (frame_start) begin
                e_dir  = m_ctl[7];
                e_en   = m_ctl[6];
                e_iref = m_hi[7] ? m_ref[7:4] : m_ref[3:0];
                per    = {m_hi[6:0], m_lo};
                if (per == 0) per = 1;
                left   = m_ctl[6] ? int'(m_ctl[5:0]) * 4 : 0;
                nxt    = cyc + per;
                e_step = 0;
            end else if (left > 0 && cyc == nxt) begin
                e_step = 1;
                left   = left - 1;
                nxt    = nxt + per;
            end else begin
                e_step = 0;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_ctl = wr_data;
                    2'd1: m_lo  = wr_data;
                    2'd2: m_hi  = wr_data;
                    default: m_ref = wr_data;
                endcase
            end
        end
    end

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(step_o == e_step, "R4 step timing", step_o, e_step);
            chk(dir_o == e_dir, "R1 direction", dir_o, e_dir);
            chk(drive_en_o == e_en, "R2 drive enable", drive_en_o, e_en);
            chk(iref_o == e_iref, "R7 reference code", iref_o, e_iref);
            if (step_o) pulses++;
            if (step_o && prev_step) consec++;
            prev_step = step_o;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        pulses = 0;
        consec = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R10: reset state
        chk(step_o == 0 && dir_o == 0 && drive_en_o == 0 && iref_o == 0,
            "R10 reset outputs", {step_o, dir_o, drive_en_o, iref_o}, 0);
        pulses = 0;
        idle(20);
        chk(pulses == 0, "R10 no pulse before first frame", pulses, 0);

        // R11 addresses, R1 reverse, R3 count 3 -> 12 pulses, R7 low nibble
        wr(2'd0, 8'hC3);
        wr(2'd1, 8'd5);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'hA5);
        frame();
        idle(12 * 5 + 4);
        chk(pulses == 12, "R3 twelve pulses", pulses, 12);
        chk(consec == 0, "R5 single-cycle pulses", consec, 0);
        chk(dir_o == 1, "R1 reverse", dir_o, 1);
        chk(iref_o == 4'h5, "R7 low nibble", iref_o, 5);
        idle(40);
        chk(pulses == 12, "R9 quiet after burst", pulses, 12);

        // R7 high nibble, R1 forward, interval 1 with count 2 -> 8 pulses
        wr(2'd0, 8'h42);
        wr(2'd1, 8'd1);
        wr(2'd2, 8'h80);
        frame();
        idle(12);
        chk(pulses == 8, "R3 eight back-to-back pulses", pulses, 8);
        chk(iref_o == 4'hA, "R7 high nibble", iref_o, 10);
        chk(dir_o == 0, "R1 forward", dir_o, 0);

        // R4: interval 0 acts as 1
        wr(2'd0, 8'h41);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'h00);
        frame();
        idle(6);
        chk(pulses == 4, "R4 zero interval acts as one", pulses, 4);

        // R6 / R2: enable cleared
        wr(2'd0, 8'h05);
        wr(2'd1, 8'd2);
        frame();
        idle(40);
        chk(pulses == 0, "R6 disabled frame has no pulses", pulses, 0);
        chk(drive_en_o == 0, "R2 high impedance", drive_en_o, 0);

        // R3: count zero
        wr(2'd0, 8'h40);
        frame();
        idle(20);
        chk(pulses == 0, "R3 zero count", pulses, 0);
        chk(drive_en_o == 1, "R2 conduct", drive_en_o, 1);

        // R8: mid-burst write deferred to the next frame
        wr(2'd0, 8'hC4);
        wr(2'd1, 8'd3);
        frame();
        idle(10);
        wr(2'd0, 8'h41);
        idle(2);
        chk(dir_o == 1, "R8 write deferred", dir_o, 1);
        idle(16 * 3);
        chk(pulses == 16, "R8 burst kept old count", pulses, 16);
        frame();
        idle(4 * 3 + 4);
        chk(pulses == 4, "R8 new count after frame", pulses, 4);
        chk(dir_o == 0, "R8 new direction after frame", dir_o, 0);

        // R8: a strobe during a burst restarts it
        wr(2'd0, 8'h42);
        wr(2'd1, 8'd4);
        frame();
        idle(9);
        frame();
        idle(8 * 4 + 4);
        chk(pulses == 8, "R8 restart gives full burst", pulses, 8);

        // R4: nine-bit interval 261 through the upper byte
        wr(2'd0, 8'h41);
        wr(2'd1, 8'h05);
        wr(2'd2, 8'h01);
        frame();
        idle(260);
        chk(pulses == 0, "R4 no pulse before first interval", pulses, 0);
        idle(4 * 261);
        chk(pulses == 4, "R4 long interval burst", pulses, 4);
        chk(consec == 0, "R5 single-cycle pulses long", consec, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule